// File: doc/BRIEF.md
# String Write-Readback Memory Sequencer

This block loads a fixed character string into an on-chip synchronous-read memory and reads it back. A loader state machine, started by a single `start` pulse, writes one byte per clock into consecutive addresses beginning at zero. After its final write it sends a one-cycle handoff pulse to a fetch state machine. The fetch machine then issues one read address per clock.

The memory returns data one cycle after each address is applied. The fetch machine therefore tracks a registered copy of its read enable, and that copy marks the byte on the output bus as valid. After the last byte it raises a sticky completion flag. The string and its length are elaboration-time parameters. The memory resolves a same-address read and write in favour of the new data.

Reset is asynchronous and active-low, with synchronised release. It returns both machines to their idle states and clears the valid and completion outputs. It leaves the memory contents untouched.

Top module: `strseq_top`

## Requirements
- R1: While `rst_n` is low, and from the moment it falls, `out_valid` and `seq_done` are 0. After `rst_n` rises, two clock edges pass before the machines leave reset.
- R2: A `start` sampled high in idle makes the loader write character i of the string to address i, one per cycle, for addresses 0 to STR_LEN-1 in increasing order. The first character is the leftmost character of the string parameter.
- R3: No read of the memory is issued in a cycle that has a write. The fetch machine reads nothing before the loader has written its last character.
- R4: The handoff pulse is exactly one cycle long. Once the loader has finished, `start` has no effect until the next reset.
- R5: Read data is presented in the cycle after its address is issued. Counting the edge that samples `start` as edge 0, the first `out_valid` follows edge STR_LEN+2, and the bytes follow on consecutive cycles.
- R6: Exactly STR_LEN bytes are output per run, and they equal the string in order. When `out_valid` is low, `out_byte` is 0.
- R7: `seq_done` rises in the cycle after the last valid byte and stays high until reset. No `out_valid` occurs while it is high.
- R8: The memory is write-first: a read and a write of the same address in one cycle return the newly written byte one cycle later.
- R9: A read of one address during a write to another returns the previously stored byte. With the write enable low, the memory contents do not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Starts the loader when it is idle |
| out_byte | output | DATA_W | Byte read back from the memory, 0 when not valid |
| out_valid | output | 1 | `out_byte` carries a string character this cycle |
| seq_done | output | 1 | Sticky flag: the whole string has been output |

## Verification
A wrong loader index or a wrong handoff shows up as a wrong or misplaced byte. It is visible at the ports as soon as the fetch machine reaches that address, about STR_LEN cycles after the fault. A wrong read-latency alignment shifts every byte by one position, so the first valid cycle already shows the wrong character. A missing sticky hold or a missing guard against repeated `start` shows up either as a dropped `seq_done` or as extra `out_valid` cycles after completion. The write-first rule is exercised on a standalone memory instance, where a read-first memory would return the stale byte in the very next cycle.

// File: rtl/strseq_pkg.sv
package strseq_pkg;

  typedef enum logic [1:0] {
    LD_IDLE = 2'd0,
    LD_RUN  = 2'd1,
    LD_END  = 2'd2
  } ld_state_e;

  typedef enum logic [1:0] {
    FT_IDLE = 2'd0,
    FT_RUN  = 2'd1,
    FT_END  = 2'd2
  } ft_state_e;

endpackage

// File: rtl/strseq_ram.sv
module strseq_ram #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] store [DEPTH];
  logic              fwd_hit;

  // same-address collision: return the incoming byte (write-first)
  assign fwd_hit = wr_en && (wr_addr == rd_addr);

  always_ff @(posedge clk) begin
    if (wr_en) begin
      store[wr_addr] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rd_en) begin
      rd_data <= fwd_hit ? wr_data : store[rd_addr];
    end
  end

endmodule

// File: rtl/strseq_loader.sv
module strseq_loader
  import strseq_pkg::*;
#(
  parameter int                        ADDR_W   = 10,
  parameter int                        DATA_W   = 8,
  parameter int                        STR_LEN  = 13,
  parameter logic [STR_LEN*DATA_W-1:0] STR_TEXT = "Hello, World!"
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              handoff
);

  localparam logic [ADDR_W-1:0] LAST_IDX = ADDR_W'(STR_LEN - 1);

  ld_state_e         state_q, state_d;
  logic [ADDR_W-1:0] idx_q, idx_d;
  logic              idx_en;
  logic              handoff_q, handoff_d;

  // next-state logic
  always_comb begin
    state_d   = state_q;
    idx_d     = idx_q;
    idx_en    = 1'b0;
    handoff_d = 1'b0;
    wr_en     = 1'b0;
    unique case (state_q)
      LD_IDLE: begin
        if (start) begin
          state_d = LD_RUN;
          idx_d   = '0;
          idx_en  = 1'b1;
        end
      end
      LD_RUN: begin
        wr_en = 1'b1;
        if (idx_q == LAST_IDX) begin
          state_d   = LD_END;
          handoff_d = 1'b1;
        end else begin
          idx_d  = idx_q + 1'b1;
          idx_en = 1'b1;
        end
      end
      LD_END: begin
        state_d = LD_END;
      end
      default: begin
        state_d = LD_IDLE;
      end
    endcase
  end

  // constant character table, selected by the write index
  always_comb begin
    wr_data = '0;
    for (int k = 0; k < STR_LEN; k++) begin
      if (idx_q == ADDR_W'(k)) begin
        wr_data = STR_TEXT[(STR_LEN-1-k)*DATA_W +: DATA_W];
      end
    end
  end

  assign wr_addr = idx_q;
  assign handoff = handoff_q;

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= LD_IDLE;
      handoff_q <= 1'b0;
    end else begin
      state_q   <= state_d;
      handoff_q <= handoff_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
    end else if (idx_en) begin
      idx_q <= idx_d;
    end
  end

endmodule

// File: rtl/strseq_fetch.sv
module strseq_fetch
  import strseq_pkg::*;
#(
  parameter int ADDR_W  = 10,
  parameter int STR_LEN = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              handoff,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              data_valid,
  output logic              all_done
);

  localparam logic [ADDR_W-1:0] LAST_IDX = ADDR_W'(STR_LEN - 1);

  ft_state_e         state_q, state_d;
  logic [ADDR_W-1:0] idx_q, idx_d;
  logic              idx_en;
  logic              last_issue;
  logic              valid_q;
  logic              last_q;
  logic              done_q;

  assign last_issue = rd_en && (idx_q == LAST_IDX);

  // next-state logic
  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    idx_en  = 1'b0;
    rd_en   = 1'b0;
    unique case (state_q)
      FT_IDLE: begin
        if (handoff) begin
          state_d = FT_RUN;
          idx_d   = '0;
          idx_en  = 1'b1;
        end
      end
      FT_RUN: begin
        rd_en = 1'b1;
        if (idx_q == LAST_IDX) begin
          state_d = FT_END;
        end else begin
          idx_d  = idx_q + 1'b1;
          idx_en = 1'b1;
        end
      end
      FT_END: begin
        state_d = FT_END;
      end
      default: begin
        state_d = FT_IDLE;
      end
    endcase
  end

  assign rd_addr    = idx_q;
  assign data_valid = valid_q;
  assign all_done   = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= FT_IDLE;
      valid_q <= 1'b0;
      last_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      valid_q <= rd_en;                // data lands one cycle after the address
      last_q  <= last_issue;
      done_q  <= done_q | last_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
    end else if (idx_en) begin
      idx_q <= idx_d;
    end
  end

endmodule

// File: rtl/strseq_top.sv
module strseq_top #(
  parameter int                        ADDR_W   = 10,
  parameter int                        DATA_W   = 8,
  parameter int                        STR_LEN  = 13,
  parameter logic [STR_LEN*DATA_W-1:0] STR_TEXT = "Hello, World!"
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic [DATA_W-1:0] out_byte,
  output logic              out_valid,
  output logic              seq_done
);

  logic              rst_meta_q;
  logic              rst_sync_n;
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data;
  logic              handoff;
  logic              rd_en;
  logic [ADDR_W-1:0] rd_addr;
  logic [DATA_W-1:0] rd_data;
  logic              data_valid;

  // reset: immediate assertion, two-stage synchronised release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  strseq_loader #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .STR_LEN (STR_LEN),
    .STR_TEXT(STR_TEXT)
  ) u_loader (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .start  (start),
    .wr_en  (wr_en),
    .wr_addr(wr_addr),
    .wr_data(wr_data),
    .handoff(handoff)
  );

  strseq_ram #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_ram (
    .clk    (clk),
    .wr_en  (wr_en),
    .wr_addr(wr_addr),
    .wr_data(wr_data),
    .rd_en  (rd_en),
    .rd_addr(rd_addr),
    .rd_data(rd_data)
  );

  strseq_fetch #(
    .ADDR_W (ADDR_W),
    .STR_LEN(STR_LEN)
  ) u_fetch (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .handoff   (handoff),
    .rd_en     (rd_en),
    .rd_addr   (rd_addr),
    .data_valid(data_valid),
    .all_done  (seq_done)
  );

  assign out_valid = data_valid;
  assign out_byte  = data_valid ? rd_data : '0;

endmodule

// File: rtl/strseq_chk.sv
module strseq_chk #(
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              rd_en,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              handoff,
  input logic              out_valid,
  input logic              seq_done
);

  AST_WRITE_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && $past(wr_en)) |-> (wr_addr == $past(wr_addr) + 1'b1)); // R2

  AST_NO_READ_WITH_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> !wr_en); // R3

  AST_HANDOFF_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    handoff |=> !handoff); // R4

  AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> out_valid); // R5

  AST_READ_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && $past(rd_en)) |-> (rd_addr == $past(rd_addr) + 1'b1)); // R6

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |=> seq_done); // R7

  AST_NO_VALID_WHEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |-> !out_valid); // R7

endmodule

bind strseq_top strseq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .wr_en    (wr_en),
  .wr_addr  (wr_addr),
  .rd_en    (rd_en),
  .rd_addr  (rd_addr),
  .handoff  (handoff),
  .out_valid(out_valid),
  .seq_done (seq_done)
);

// File: tb/strseq_top_bench.sv
`timescale 1ns/1ps
module strseq_top_bench;

  localparam int    LEN  = 13;
  localparam string TEXT = "Hello, World!";

  logic       clk;
  logic       rst_n;
  logic       start;
  logic [7:0] out_byte;
  logic       out_valid;
  logic       seq_done;

  int checks;
  int errors;
  int nbytes;
  bit finished;

  // reference model state
  bit model_run;
  int model_n;

  strseq_top u_strseq_top (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .out_byte (out_byte),
    .out_valid(out_valid),
    .seq_done (seq_done)
  );

  // standalone memory for the collision rules
  logic       p_we;
  logic [3:0] p_wa;
  logic [7:0] p_wd;
  logic       p_re;
  logic [3:0] p_ra;
  logic [7:0] p_rd;

  strseq_ram #(.ADDR_W(4), .DATA_W(8)) u_ram_probe (
    .clk    (clk),
    .wr_en  (p_we),
    .wr_addr(p_wa),
    .wr_data(p_wd),
    .rd_en  (p_re),
    .rd_addr(p_ra),
    .rd_data(p_rd)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // behavioural model: cycle count since start was accepted
  always @(posedge clk) begin
    if (!rst_n) begin
      model_run = 1'b0;
      model_n   = 0;
    end else if (model_run) begin
      model_n = model_n + 1;
    end else if (start) begin
      model_run = 1'b1;
      model_n   = 0;
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      bit exp_v;
      bit exp_d;
      int exp_b;
      exp_v = model_run && (model_n >= LEN + 2) && (model_n <= 2*LEN + 1);
      exp_d = model_run && (model_n >= 2*LEN + 2);
      exp_b = exp_v ? int'(TEXT[model_n - LEN - 2]) : 0;
      chk(out_valid == exp_v, "R5", "out_valid", out_valid, exp_v);
      chk(seq_done == exp_d, "R7", "seq_done", seq_done, exp_d);
      chk(out_byte == exp_b[7:0], "R6", "out_byte", out_byte, exp_b);
      if (out_valid) nbytes++;
    end
  end

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: actual 1 expected 0");
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    checks = 0; errors = 0; nbytes = 0; finished = 1'b0;
    rst_n = 1'b0; start = 1'b0;
    p_we = 1'b0; p_wa = '0; p_wd = '0; p_re = 1'b0; p_ra = '0;
    cyc(3);
    chk(out_valid == 1'b0, "R1", "valid in reset", out_valid, 0);
    chk(seq_done == 1'b0, "R1", "done in reset", seq_done, 0);

    // memory collision rules on the probe instance
    p_we = 1'b1; p_wa = 4'd3; p_wd = 8'h5A; p_re = 1'b1; p_ra = 4'd3;
    cyc(1);
    chk(p_rd == 8'h5A, "R8", "write-first same address", p_rd, 8'h5A);
    p_we = 1'b1; p_wa = 4'd4; p_wd = 8'h11; p_ra = 4'd3;
    cyc(1);
    chk(p_rd == 8'h5A, "R9", "read other address", p_rd, 8'h5A);
    p_we = 1'b0; p_wa = 4'd3; p_wd = 8'hFF; p_ra = 4'd3;
    cyc(1);
    chk(p_rd == 8'h5A, "R9", "no write when disabled", p_rd, 8'h5A);
    p_ra = 4'd4;
    cyc(1);
    chk(p_rd == 8'h11, "R9", "earlier write kept", p_rd, 8'h11);
    p_re = 1'b0;

    // run 1: single-cycle start
    rst_n = 1'b1;
    cyc(4);
    nbytes = 0;
    start = 1'b1; cyc(1); start = 1'b0;
    cyc(40);
    chk(nbytes == LEN, "R6", "byte count run 1", nbytes, LEN);
    chk(seq_done == 1'b1, "R7", "done after run 1", seq_done, 1);

    // start after completion is ignored
    start = 1'b1; cyc(1); start = 1'b0;
    cyc(30);
    chk(nbytes == LEN, "R4", "no output after late start", nbytes, LEN);

    // run 2: reset, then start held high for several cycles
    rst_n = 1'b0;
    cyc(2);
    chk(seq_done == 1'b0, "R1", "done cleared by reset", seq_done, 0);
    rst_n = 1'b1;
    cyc(4);
    nbytes = 0;
    start = 1'b1; cyc(6); start = 1'b0;
    cyc(40);
    chk(nbytes == LEN, "R2", "byte count run 2", nbytes, LEN);

    // run 3: reset during readback clears outputs at once
    rst_n = 1'b0; cyc(2); rst_n = 1'b1; cyc(4);
    start = 1'b1; cyc(1); start = 1'b0;
    cyc(20);
    rst_n = 1'b0;
    #1;
    chk(out_valid == 1'b0, "R1", "valid cleared asynchronously", out_valid, 0);
    cyc(2);
    rst_n = 1'b1;
    cyc(4);
    nbytes = 0;
    start = 1'b1; cyc(1); start = 1'b0;
    cyc(40);
    chk(nbytes == LEN, "R3", "byte count after reset mid-run", nbytes, LEN);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule